// File: doc/BRIEF.md
# Latched Parity Transceiver

This block sits between two symmetric buses, A and B, each carrying a data word split into byte-wide lanes with one parity bit per lane. Each direction owns a transparent latch with its own enable: the A-side latch captures the A bus and feeds the B outputs, and the B-side latch captures the B bus and feeds the A outputs. While an enable is high the latch passes its input straight through. While it is low the latch shows the value it captured at the last clock edge at which the enable was high.

A mode input chooses the source of the outgoing parity bits. They are either regenerated from the latched data or passed through unchanged from the latched incoming parity. A polarity input selects odd or even parity, and the choice applies to generation and to checking alike. Both latches are checked continuously, whatever the mode. Any lane with a parity fault pulls the active-low error flag of its side low.

Each output bus has a drive-enable that stands in for a tri-state pad control. The enables come from active-low direction requests, and the A-to-B direction wins when both requests are asserted. Reset clears both latches, turns off both drivers and holds both error flags inactive.

Top module: `lpt_xcvr`

## Requirements
- R1: While rst_n is low, a_oe and b_oe are 0 and err_a_n and err_b_n are 1. After reset, a latch whose enable has stayed low outputs all-zero data and parity.
- R2: While lea is 1, b_data_o equals a_data_i in the same cycle, with no clock delay.
- R3: While lea is 0, b_data_o and the fed-through parity show the A input captured at the last rising clock edge at which lea was 1.
- R4: With feed_thru = 0, b_par_o[k] equals the XOR of latched A lane k, inverted when odd_sel = 1. Lane k is data bits [8k+7:8k].
- R5: With feed_thru = 1, b_par_o[k] equals the latched A parity bit k, unchanged.
- R6: err_a_n is 0 exactly when some lane k of the A-side latch has a bad count of ones over its data plus parity bit k. With odd_sel = 0 the count must be even; with odd_sel = 1 it must be odd.
- R7: Parity checking applies with feed_thru = 1 as well as with feed_thru = 0.
- R8: oeab_n = 0 gives b_oe = 1. a_oe = 1 only when oeba_n = 0 and oeab_n = 1. The two enables are never both 1.
- R9: The B-to-A path mirrors the A-to-B path: it uses leb, the B-side latch, a_data_o, a_par_o and err_b_n under rules R2 to R7.
- R10: The two latches work independently. One can hold while the other is transparent, and both can be checked in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for latch capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| lea | input | 1 | A-side latch enable (1 = transparent) |
| leb | input | 1 | B-side latch enable (1 = transparent) |
| oeab_n | input | 1 | Active-low request to drive the B bus |
| oeba_n | input | 1 | Active-low request to drive the A bus |
| feed_thru | input | 1 | 0 = generate parity, 1 = pass incoming parity through |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| a_data_i | input | 16 | A bus data in |
| a_par_i | input | 2 | A bus lane parity in |
| b_data_i | input | 16 | B bus data in |
| b_par_i | input | 2 | B bus lane parity in |
| a_data_o | output | 16 | Data to drive onto the A bus |
| a_par_o | output | 2 | Parity to drive onto the A bus |
| a_oe | output | 1 | Drive enable for the A bus pads |
| b_data_o | output | 16 | Data to drive onto the B bus |
| b_par_o | output | 2 | Parity to drive onto the B bus |
| b_oe | output | 1 | Drive enable for the B bus pads |
| err_a_n | output | 1 | Active-low A-side parity error |
| err_b_n | output | 1 | Active-low B-side parity error |

## Verification
The bench walks every combination of parity mode and polarity. It injects a fault into one lane, into the other lane, and into both, so a flag that checks only lane 0, or that checks with the wrong polarity, gives a wrong error value. Hold sequences change the input while an enable is low. A latch that stays transparent, or that captures the wrong edge, shows the new data instead of the held word. The bench drives both direction requests at once, which exposes a priority inverted toward B-to-A or both drivers on together. It also resets in the middle of the run with the enables low; a design that does not clear its latches then returns stale data afterwards.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

   typedef enum logic {
      PAR_EVEN = 1'b0,
      PAR_ODD  = 1'b1
   } par_pol_e;

   typedef enum logic {
      PSRC_GEN  = 1'b0,
      PSRC_FEED = 1'b1
   } par_src_e;

   function automatic logic pol_bit(input par_pol_e pol);
      return (pol == PAR_ODD);
   endfunction

endpackage

// File: rtl/lpt_latch.sv
module lpt_latch #(
   parameter int W = 18
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         le,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= '0;
      end else if (le) begin
         held_q <= d;
      end
   end

   assign q = le ? d : held_q;

endmodule

// File: rtl/lpt_lane.sv
module lpt_lane
   import lpt_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] d,
   input  logic              p,
   input  par_pol_e          pol,
   input  par_src_e          src,
   output logic              par_o,
   output logic              bad
);

   logic red_x;
   logic gen_p;

   assign red_x = ^d;
   assign gen_p = red_x ^ pol_bit(pol);
   assign par_o = (src == PSRC_FEED) ? p : gen_p;
   assign bad   = red_x ^ p ^ pol_bit(pol);

endmodule

// File: rtl/lpt_side.sv
module lpt_side
   import lpt_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   localparam int DW    = LANE_W * LANES,
   localparam int LW    = DW + LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             le,
   input  logic [DW-1:0]    data_i,
   input  logic [LANES-1:0] par_i,
   input  par_pol_e         pol,
   input  par_src_e         src,
   output logic [DW-1:0]    data_o,
   output logic [LANES-1:0] par_o,
   output logic             err_n
);

   logic [LW-1:0]    lat_q;
   logic [DW-1:0]    lat_data;
   logic [LANES-1:0] lat_par;
   logic [LANES-1:0] lane_bad;

   lpt_latch #(.W(LW)) u_lat (
      .clk   (clk),
      .rst_n (rst_n),
      .le    (le),
      .d     ({data_i, par_i}),
      .q     (lat_q)
   );

   assign lat_data = lat_q[LW-1:LANES];
   assign lat_par  = lat_q[LANES-1:0];
   assign data_o   = lat_data;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      lpt_lane #(.LANE_W(LANE_W)) u_lane (
         .d     (lat_data[k*LANE_W +: LANE_W]),
         .p     (lat_par[k]),
         .pol   (pol),
         .src   (src),
         .par_o (par_o[k]),
         .bad   (lane_bad[k])
      );
   end

   assign err_n = ~(rst_n & (|lane_bad));

endmodule

// File: rtl/lpt_xcvr.sv
module lpt_xcvr
   import lpt_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   localparam int DW    = LANE_W * LANES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lea,
   input  logic             leb,
   input  logic             oeab_n,
   input  logic             oeba_n,
   input  logic             feed_thru,
   input  logic             odd_sel,
   input  logic [DW-1:0]    a_data_i,
   input  logic [LANES-1:0] a_par_i,
   input  logic [DW-1:0]    b_data_i,
   input  logic [LANES-1:0] b_par_i,
   output logic [DW-1:0]    a_data_o,
   output logic [LANES-1:0] a_par_o,
   output logic             a_oe,
   output logic [DW-1:0]    b_data_o,
   output logic [LANES-1:0] b_par_o,
   output logic             b_oe,
   output logic             err_a_n,
   output logic             err_b_n
);

   if (LANE_W < 1) begin : g_bad_lane_w
      $error("lpt_xcvr: LANE_W must be at least 1");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("lpt_xcvr: LANES must be at least 1");
   end

   par_pol_e pol;
   par_src_e src;

   assign pol = par_pol_e'(odd_sel);
   assign src = par_src_e'(feed_thru);

   // A-side latch captures the A bus and feeds the B outputs
   lpt_side #(.LANE_W(LANE_W), .LANES(LANES)) u_side_a (
      .clk    (clk),
      .rst_n  (rst_n),
      .le     (lea),
      .data_i (a_data_i),
      .par_i  (a_par_i),
      .pol    (pol),
      .src    (src),
      .data_o (b_data_o),
      .par_o  (b_par_o),
      .err_n  (err_a_n)
   );

   // B-side latch captures the B bus and feeds the A outputs
   lpt_side #(.LANE_W(LANE_W), .LANES(LANES)) u_side_b (
      .clk    (clk),
      .rst_n  (rst_n),
      .le     (leb),
      .data_i (b_data_i),
      .par_i  (b_par_i),
      .pol    (pol),
      .src    (src),
      .data_o (a_data_o),
      .par_o  (a_par_o),
      .err_n  (err_b_n)
   );

   // A-to-B request wins a conflict; reset keeps both pads released
   assign b_oe = rst_n & ~oeab_n;
   assign a_oe = rst_n & ~oeba_n & oeab_n;

endmodule

// File: rtl/lpt_xcvr_chk.sv
module lpt_xcvr_chk #(
   parameter int LANE_W = 8,
   parameter int LANES  = 2,
   localparam int DW    = LANE_W * LANES
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lea,
   input logic             leb,
   input logic             oeab_n,
   input logic             feed_thru,
   input logic             odd_sel,
   input logic [DW-1:0]    a_data_i,
   input logic [LANES-1:0] a_par_i,
   input logic [DW-1:0]    b_data_i,
   input logic [LANES-1:0] b_par_i,
   input logic [DW-1:0]    b_data_o,
   input logic [LANES-1:0] b_par_o,
   input logic [LANES-1:0] a_par_o,
   input logic             a_oe,
   input logic             b_oe,
   input logic             err_a_n,
   input logic             err_b_n
);

   logic [LANES-1:0] in_bad_a;
   logic [LANES-1:0] in_bad_b;

   always_comb begin
      for (int k = 0; k < LANES; k++) begin
         in_bad_a[k] = (^a_data_i[k*LANE_W +: LANE_W]) ^ a_par_i[k] ^ odd_sel;
         in_bad_b[k] = (^b_data_i[k*LANE_W +: LANE_W]) ^ b_par_i[k] ^ odd_sel;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!a_oe && !b_oe && err_a_n && err_b_n);
      end
   end

   assert_flow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lea |-> (b_data_o == a_data_i));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!lea && $past(!lea)) |-> $stable(b_data_o));

   assert_feed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lea && feed_thru) |-> (b_par_o == a_par_i));

   assert_feed_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (leb && feed_thru) |-> (a_par_o == b_par_i));

   for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
      assert_gen_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (lea && !feed_thru) |->
            (b_par_o[k] == ((^a_data_i[k*LANE_W +: LANE_W]) ^ odd_sel)));
   end

   assert_err_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lea && (|in_bad_a)) |-> !err_a_n);

   assert_err_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (leb && (|in_bad_b)) |-> !err_b_n);

   assert_oe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_oe && b_oe));

   assert_ab_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !oeab_n |-> b_oe);

endmodule

bind lpt_xcvr lpt_xcvr_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lea       (lea),
   .leb       (leb),
   .oeab_n    (oeab_n),
   .feed_thru (feed_thru),
   .odd_sel   (odd_sel),
   .a_data_i  (a_data_i),
   .a_par_i   (a_par_i),
   .b_data_i  (b_data_i),
   .b_par_i   (b_par_i),
   .b_data_o  (b_data_o),
   .b_par_o   (b_par_o),
   .a_par_o   (a_par_o),
   .a_oe      (a_oe),
   .b_oe      (b_oe),
   .err_a_n   (err_a_n),
   .err_b_n   (err_b_n)
);

// File: tb/sim_lpt_xcvr.sv
module sim_lpt_xcvr;

   localparam int LW = 8;
   localparam int NL = 2;
   localparam int DW = LW * NL;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lea = 1'b0, leb = 1'b0, oeab_n = 1'b1, oeba_n = 1'b1;
   logic feed_thru = 1'b0, odd_sel = 1'b0;
   logic [DW-1:0] a_data_i = '0, b_data_i = '0;
   logic [NL-1:0] a_par_i = '0, b_par_i = '0;
   logic [DW-1:0] a_data_o, b_data_o;
   logic [NL-1:0] a_par_o, b_par_o;
   logic a_oe, b_oe, err_a_n, err_b_n;

   always #4 clk = ~clk;

   lpt_xcvr #(.LANE_W(LW), .LANES(NL)) u0 (
      .clk(clk), .rst_n(rst_n), .lea(lea), .leb(leb),
      .oeab_n(oeab_n), .oeba_n(oeba_n), .feed_thru(feed_thru), .odd_sel(odd_sel),
      .a_data_i(a_data_i), .a_par_i(a_par_i), .b_data_i(b_data_i), .b_par_i(b_par_i),
      .a_data_o(a_data_o), .a_par_o(a_par_o), .a_oe(a_oe),
      .b_data_o(b_data_o), .b_par_o(b_par_o), .b_oe(b_oe),
      .err_a_n(err_a_n), .err_b_n(err_b_n)
   );

   typedef struct {
      logic [DW+NL+DW+NL+4-1:0] vec;
      string tag;
   } exp_t;

   exp_t sb_q[$];
   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [DW+NL-1:0] ref_a = '0;
   logic [DW+NL-1:0] ref_b = '0;

   function automatic logic [NL-1:0] gen_par(input logic [DW-1:0] d, input logic od);
      logic [NL-1:0] g;
      for (int k = 0; k < NL; k++) g[k] = (^d[k*LW +: LW]) ^ od;
      return g;
   endfunction

   function automatic logic any_bad(input logic [DW-1:0] d, input logic [NL-1:0] p,
                                    input logic od);
      logic b = 1'b0;
      for (int k = 0; k < NL; k++) b |= (^d[k*LW +: LW]) ^ p[k] ^ od;
      return b;
   endfunction

   task automatic apply(input logic r, input logic la, input logic lb,
                        input logic oab, input logic oba, input logic ft, input logic od,
                        input logic [DW-1:0] ad, input logic [NL-1:0] ap,
                        input logic [DW-1:0] bd, input logic [NL-1:0] bp,
                        input string tag);
      logic [DW+NL-1:0] la_v, lb_v;
      logic [NL-1:0] bpo, apo;
      exp_t e;
      @(posedge clk);
      #1;
      rst_n = r; lea = la; leb = lb; oeab_n = oab; oeba_n = oba;
      feed_thru = ft; odd_sel = od;
      a_data_i = ad; a_par_i = ap; b_data_i = bd; b_par_i = bp;
      if (!r) begin
         ref_a = '0;
         ref_b = '0;
      end
      la_v = la ? {ad, ap} : ref_a;
      lb_v = lb ? {bd, bp} : ref_b;
      bpo = ft ? la_v[NL-1:0] : gen_par(la_v[DW+NL-1:NL], od);
      apo = ft ? lb_v[NL-1:0] : gen_par(lb_v[DW+NL-1:NL], od);
      e.vec = {la_v[DW+NL-1:NL], bpo, lb_v[DW+NL-1:NL], apo,
               r & ~oba & oab, r & ~oab,
               ~(r & any_bad(la_v[DW+NL-1:NL], la_v[NL-1:0], od)),
               ~(r & any_bad(lb_v[DW+NL-1:NL], lb_v[NL-1:0], od))};
      e.tag = tag;
      sb_q.push_back(e);
      if (r && la) ref_a = {ad, ap};
      if (r && lb) ref_b = {bd, bp};
   endtask

   // monitor: compares half a cycle after each vector is applied
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            exp_t e;
            logic [DW+NL+DW+NL+4-1:0] act;
            e = sb_q.pop_front();
            act = {b_data_o, b_par_o, a_data_o, a_par_o, a_oe, b_oe, err_a_n, err_b_n};
            n_vec++;
            if (act !== e.vec) begin
               n_bad++;
               $display("FAIL %s: got %h expected %h", e.tag, act, e.vec);
            end
         end
      end
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] pats [4];
      pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h0180; pats[3] = 16'h7E35;

      // R1: reset state, drivers off, flags inactive, latches cleared
      apply(0, 0, 0, 1, 1, 0, 0, 16'hA5A5, 2'b11, 16'h3C3C, 2'b01, "R1 reset idle");
      apply(0, 1, 1, 0, 0, 1, 1, 16'h0001, 2'b00, 16'h0100, 2'b00, "R1 reset with requests");
      apply(1, 0, 0, 1, 1, 1, 0, 16'h5555, 2'b10, 16'hAAAA, 2'b01, "R1 latches cleared");

      // R2 R4 R9: transparent, generate even and odd
      apply(1, 1, 1, 1, 1, 0, 0, 16'h1234, 2'b00, 16'h00FF, 2'b00, "R2 R4 R9 gen even");
      apply(1, 1, 1, 1, 1, 0, 1, 16'h8001, 2'b11, 16'hFE01, 2'b00, "R2 R4 R9 gen odd");

      // every mode/polarity/pattern with lane fault injection: R4 R5 R6 R7 R9
      for (int ft = 0; ft < 2; ft++) begin
         for (int od = 0; od < 2; od++) begin
            for (int p = 0; p < 4; p++) begin
               for (int inj = 0; inj < 4; inj++) begin
                  logic [NL-1:0] ga, gb;
                  ga = gen_par(pats[p], od[0]) ^ inj[1:0];
                  gb = gen_par(~pats[p], od[0]) ^ inj[1:0] ^ 2'b10;
                  apply(1, 1, 1, 1, 1, ft[0], od[0], pats[p], ga, ~pats[p], gb,
                        "R4 R5 R6 R7 R9 mode sweep");
               end
            end
         end
      end

      // R3 R10: hold on A while B stays transparent, then hold B
      apply(1, 1, 1, 1, 1, 1, 0, 16'hC3A1, 2'b01, 16'h0F0F, 2'b00, "R3 capture A");
      apply(1, 0, 1, 1, 1, 1, 0, 16'h1111, 2'b10, 16'h0F0E, 2'b11, "R3 R10 A held B flows");
      apply(1, 0, 1, 1, 1, 1, 1, 16'h2222, 2'b11, 16'h7777, 2'b01, "R3 R10 A held odd");
      apply(1, 1, 0, 1, 1, 0, 0, 16'h4001, 2'b00, 16'hFFFF, 2'b11, "R10 B held A flows");
      apply(1, 0, 0, 1, 1, 1, 0, 16'h0000, 2'b00, 16'h0000, 2'b00, "R3 R9 both held");

      // R8: direction requests
      apply(1, 1, 1, 0, 1, 0, 0, 16'h1357, 2'b00, 16'h2468, 2'b00, "R8 A to B only");
      apply(1, 1, 1, 1, 0, 0, 0, 16'h1357, 2'b00, 16'h2468, 2'b00, "R8 B to A only");
      apply(1, 1, 1, 0, 0, 0, 0, 16'h1357, 2'b00, 16'h2468, 2'b00, "R8 both requested");
      apply(1, 1, 1, 1, 1, 0, 0, 16'h1357, 2'b00, 16'h2468, 2'b00, "R8 none requested");

      // R1: mid-run reset clears held contents
      apply(1, 1, 1, 0, 0, 1, 0, 16'hBEEF, 2'b01, 16'hCAFE, 2'b10, "R1 load before reset");
      apply(0, 0, 0, 0, 0, 1, 0, 16'h0000, 2'b00, 16'h0000, 2'b00, "R1 mid-run reset");
      apply(1, 0, 0, 0, 1, 1, 1, 16'hFFFF, 2'b11, 16'hFFFF, 2'b11, "R1 R6 cleared after reset");

      @(posedge clk);
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule